// File: doc/BRIEF.md
# Dual Sub-Timer With Match Interrupts

This block holds two 16-bit sub-timers behind a small register bus. Each sub-timer has a current-count register, a clock divider and a control word. The control word selects run or halt, the counting direction, and what ends a run: reaching zero, the count equalling one of six shared match registers, or nothing at all (free running). When a run ends, the sub-timer halts itself.

Only the first sub-timer is compared against the match bank. A match that ends its run sets one bit in a separate interrupt window. That window holds a write-one-to-clear status register and a mask register, and it drives a single interrupt line. The second sub-timer never raises status. It is normally left free running as a timebase. Software preloads the count, programs the divider and match value, and then writes the control word to start the run.

Reads return data one cycle after the request. A write on the same cycle as a hardware event takes priority over that event, except in the status register, where a new hit wins over an acknowledge.

Top module: `dual_subtimer`

## Requirements
- R1: After reset both counts, both dividers, all match registers, status and mask read 0. Both control words read 0x10 (halted), and `irq_o` is low.
- R2: Main-window word offsets are as follows. Sub-timer 1 has count at 0x00, divider at 0x04 and control at 0x08. Sub-timer 2 has count at 0x0C, divider at 0x10 and control at 0x14. Match k (k = 0..5) is at 0x18 + 4k. The interrupt window has status at 0x00 and mask at 0x04. Written values read back. An unmapped address reads 0. `bus_rdata` is valid on the cycle after `bus_rd`.
- R3: Control bit 4 set halts the count and the count holds its value. With bit 4 clear, the count advances by one per step: up when bit 3 is set, down when bit 3 is clear.
- R4: A divider value D makes the count advance once every D+1 clocks. The first step comes D+1 clocks after the starting control write.
- R5: Control bits 2:0 = 0 ends the run when the count reaches 0. The block sets control bit 4 itself and raises no status bit.
- R6: On sub-timer 1, control bits 2:0 = c (1..6) end the run on the step where the count equals match register c-1. The block sets control bit 4 and status bit c-1.
- R7: Control bits 2:0 = 7 wrap the count modulo 2^16 and never halt it.
- R8: Sub-timer 2 never sets a status bit. Its codes 1..6 run it like code 7.
- R9: Writing 1 to a status bit clears it. A hit on the same cycle as the clearing write leaves the bit set.
- R10: `irq_o` is the registered OR of status AND mask. It rises one clock after the status bit is set and stays low while the mask bit is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_irqwin | input | 1 | 1 selects the interrupt window, 0 the timer window |
| bus_addr | input | 8 | Byte address within the selected window |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| irq_o | output | 1 | Registered interrupt output |

## Verification
The bench counts exact step edges in several cases: the divider, a wrap through zero in free-running mode, and a match hit. An off-by-one in the prescaler or in the termination compare therefore shows up as a count one step off. In one test an acknowledge write lands on the same edge as a match hit. A design that let the clear win would lose that interrupt. The bench checks `irq_o` on the cycle the status bit is set and on the cycle after, which catches a combinational or doubly registered interrupt path. It also runs sub-timer 2 in a match code past the match value, so a design that compared both sub-timers would halt it or raise status.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;
  localparam int CTL_W    = 5;
  localparam int CTL_HALT = 4;
  localparam int CTL_UP   = 3;
  localparam logic [2:0] END_ZERO = 3'd0;
  localparam logic [2:0] END_FREE = 3'd7;
  localparam int WORDS_PER_CH = 3;
  localparam int MATCH_WORD   = 6;
endpackage

// File: rtl/dtmr_channel.sv
module dtmr_channel
  import dtmr_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int N_MATCH   = 6,
  parameter bit USE_MATCH = 1'b1
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wr_cnt,
  input  logic                           wr_div,
  input  logic                           wr_ctl,
  input  logic [CNT_W-1:0]               wdata,
  input  logic [N_MATCH-1:0][CNT_W-1:0]  match_i,
  output logic [CNT_W-1:0]               cnt_o,
  output logic [CNT_W-1:0]               div_o,
  output logic [CTL_W-1:0]               ctl_o,
  output logic [N_MATCH-1:0]             hit_o
);
  logic [CNT_W-1:0] cnt_q, div_q, presc_q, nxt;
  logic [CTL_W-1:0] ctl_q;
  logic running, advance, zero_end, stop_now;
  logic [2:0] code;
  logic [N_MATCH-1:0] hit;

  always_comb begin
    running  = !ctl_q[CTL_HALT];
    code     = ctl_q[2:0];
    advance  = running && (presc_q == div_q) && !wr_cnt && !wr_ctl;
    nxt      = ctl_q[CTL_UP] ? cnt_q + 1'b1 : cnt_q - 1'b1;
    zero_end = (code == END_ZERO) && (nxt == '0);
    for (int k = 0; k < N_MATCH; k++)
      hit[k] = USE_MATCH && advance && (code == 3'(k + 1)) && (nxt == match_i[k]);
    stop_now = advance && (zero_end || (|hit));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      div_q   <= '0;
      presc_q <= '0;
      ctl_q   <= CTL_W'(1) << CTL_HALT;
    end else begin
      if (!running || wr_ctl || wr_div || presc_q == div_q) presc_q <= '0;
      else presc_q <= presc_q + 1'b1;
      if (wr_div) div_q <= wdata;
      if (wr_cnt) cnt_q <= wdata;
      else if (advance) cnt_q <= nxt;
      if (wr_ctl) ctl_q <= wdata[CTL_W-1:0];
      else if (stop_now) ctl_q[CTL_HALT] <= 1'b1;
    end
  end

  assign cnt_o = cnt_q;
  assign div_o = div_q;
  assign ctl_o = ctl_q;
  assign hit_o = hit;

  assert_halt_holds_R3: assert property (@(posedge clk) disable iff (rst)
    (ctl_q[CTL_HALT] && !wr_cnt) |=> (cnt_q == $past(cnt_q)));

  assert_single_step_R4: assert property (@(posedge clk) disable iff (rst)
    !wr_cnt |=> ((cnt_q == $past(cnt_q)) || (cnt_q == CNT_W'($past(cnt_q) + 1'b1))
                 || (cnt_q == CNT_W'($past(cnt_q) - 1'b1))));

  assert_zero_end_R5: assert property (@(posedge clk) disable iff (rst)
    ($rose(ctl_q[CTL_HALT]) && !$past(wr_ctl) && ctl_q[2:0] == END_ZERO) |-> (cnt_q == '0));

  assert_free_runs_R7: assert property (@(posedge clk) disable iff (rst)
    (!ctl_q[CTL_HALT] && ctl_q[2:0] == END_FREE && !wr_ctl) |=> !ctl_q[CTL_HALT]);
endmodule

// File: rtl/dtmr_irq.sv
module dtmr_irq #(
  parameter int N_SRC = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] set_i,
  input  logic             ack_we,
  input  logic             mask_we,
  input  logic [N_SRC-1:0] wdata,
  output logic [N_SRC-1:0] status_o,
  output logic [N_SRC-1:0] mask_o,
  output logic             irq_o
);
  logic [N_SRC-1:0] status_q, mask_q;
  logic irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      mask_q   <= '0;
      irq_q    <= 1'b0;
    end else begin
      status_q <= (ack_we ? (status_q & ~wdata) : status_q) | set_i;
      if (mask_we) mask_q <= wdata;
      irq_q <= |(status_q & mask_q);
    end
  end

  assign status_o = status_q;
  assign mask_o   = mask_q;
  assign irq_o    = irq_q;

  assert_ack_clears_R9: assert property (@(posedge clk) disable iff (rst)
    (ack_we && set_i == '0) |=> ((status_q & $past(wdata)) == '0));

  assert_hit_wins_R9: assert property (@(posedge clk) disable iff (rst)
    (set_i != '0) |=> ((status_q & $past(set_i)) == $past(set_i)));

  assert_mask_gate_R10: assert property (@(posedge clk) disable iff (rst)
    ((status_q & mask_q) == '0) |=> !irq_q);
endmodule

// File: rtl/dual_subtimer.sv
module dual_subtimer
  import dtmr_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int N_MATCH = 6,
  parameter int ADDR_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic              bus_irqwin,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic              irq_o
);
  localparam int N_CH   = 2;
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic aligned, main_wr, irq_wr;
  logic [N_MATCH-1:0][CNT_W-1:0] match_q;
  logic [CNT_W-1:0] cnt_w [N_CH];
  logic [CNT_W-1:0] div_w [N_CH];
  logic [CTL_W-1:0] ctl_w [N_CH];
  logic [N_MATCH-1:0] hit_w [N_CH];
  logic [N_MATCH-1:0] status_w, mask_w;
  logic [CNT_W-1:0] rd_mux, rdata_q;

  assign word    = bus_addr[ADDR_W-1:2];
  assign aligned = (bus_addr[1:0] == 2'b00);
  assign main_wr = bus_wr && !bus_irqwin && aligned;
  assign irq_wr  = bus_wr && bus_irqwin && aligned;

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    dtmr_channel #(.CNT_W(CNT_W), .N_MATCH(N_MATCH), .USE_MATCH(g == 0)) u_ch (
      .clk     (clk),
      .rst     (rst),
      .wr_cnt  (main_wr && word == WORD_W'(g * WORDS_PER_CH)),
      .wr_div  (main_wr && word == WORD_W'(g * WORDS_PER_CH + 1)),
      .wr_ctl  (main_wr && word == WORD_W'(g * WORDS_PER_CH + 2)),
      .wdata   (bus_wdata),
      .match_i (match_q),
      .cnt_o   (cnt_w[g]),
      .div_o   (div_w[g]),
      .ctl_o   (ctl_w[g]),
      .hit_o   (hit_w[g])
    );
  end

  for (genvar k = 0; k < N_MATCH; k++) begin : g_match
    always_ff @(posedge clk) begin
      if (rst) match_q[k] <= '0;
      else if (main_wr && word == WORD_W'(MATCH_WORD + k)) match_q[k] <= bus_wdata;
    end
  end

  dtmr_irq #(.N_SRC(N_MATCH)) u_irq (
    .clk      (clk),
    .rst      (rst),
    .set_i    (hit_w[0] | hit_w[1]),
    .ack_we   (irq_wr && word == WORD_W'(0)),
    .mask_we  (irq_wr && word == WORD_W'(1)),
    .wdata    (bus_wdata[N_MATCH-1:0]),
    .status_o (status_w),
    .mask_o   (mask_w),
    .irq_o    (irq_o)
  );

  always_comb begin
    rd_mux = '0;
    if (aligned) begin
      if (bus_irqwin) begin
        if (word == WORD_W'(0)) rd_mux = CNT_W'(status_w);
        else if (word == WORD_W'(1)) rd_mux = CNT_W'(mask_w);
      end else begin
        for (int c = 0; c < N_CH; c++) begin
          if (word == WORD_W'(c * WORDS_PER_CH)) rd_mux = cnt_w[c];
          if (word == WORD_W'(c * WORDS_PER_CH + 1)) rd_mux = div_w[c];
          if (word == WORD_W'(c * WORDS_PER_CH + 2)) rd_mux = CNT_W'(ctl_w[c]);
        end
        for (int k = 0; k < N_MATCH; k++)
          if (word == WORD_W'(MATCH_WORD + k)) rd_mux = match_q[k];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_mux;
  end

  assign bus_rdata = rdata_q;

  assert_no_status_sub2_R8: assert property (@(posedge clk) disable iff (rst)
    ((hit_w[0] == '0) && !(irq_wr && word == WORD_W'(0))) |=> (status_w == $past(status_w)));
endmodule

// File: tb/dual_subtimer_bench.sv
`timescale 1ns/1ps
module dual_subtimer_bench;
  logic clk = 1'b0, rst = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0, bus_irqwin = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic irq_o;
  int n_chk = 0, n_fail = 0;

  localparam logic [7:0] CNT1 = 8'h00, DIV1 = 8'h04, CTL1 = 8'h08;
  localparam logic [7:0] CNT2 = 8'h0C, DIV2 = 8'h10, CTL2 = 8'h14;
  localparam logic [7:0] STS = 8'h00, MSK = 8'h04;

  always #4 clk = ~clk;

  dual_subtimer u_dual_subtimer (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_irqwin(bus_irqwin),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  function automatic logic [7:0] mreg(input int k);
    return 8'(8'h18 + 4 * k);
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic win, input logic [7:0] a, input logic [15:0] d);
    bus_wr = 1'b1; bus_irqwin = win; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic win, input logic [7:0] a, output logic [15:0] v);
    bus_rd = 1'b1; bus_irqwin = win; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    v = bus_rdata;
  endtask

  task automatic t_reset;
    logic [15:0] v;
    rd(0, CNT1, v); check("R1 cnt1", v, 16'h0);
    rd(0, DIV1, v); check("R1 div1", v, 16'h0);
    rd(0, CTL1, v); check("R1 ctl1", v, 16'h10);
    rd(0, CTL2, v); check("R1 ctl2", v, 16'h10);
    rd(0, mreg(5), v); check("R1 match5", v, 16'h0);
    rd(1, STS, v); check("R1 status", v, 16'h0);
    rd(1, MSK, v); check("R1 mask", v, 16'h0);
    check("R1 irq", 16'(irq_o), 16'h0);
  endtask

  task automatic t_map;
    logic [15:0] v;
    wr(0, CNT2, 16'h1234); wr(0, DIV2, 16'h0005); wr(0, mreg(5), 16'hBEEF);
    wr(1, MSK, 16'h002A);
    rd(0, CNT2, v); check("R2 cnt2", v, 16'h1234);
    rd(0, DIV2, v); check("R2 div2", v, 16'h0005);
    rd(0, mreg(5), v); check("R2 match5", v, 16'hBEEF);
    rd(1, MSK, v); check("R2 mask", v, 16'h002A);
    rd(0, 8'h30, v); check("R2 unmapped", v, 16'h0);
    rd(1, 8'h08, v); check("R2 unmapped irq", v, 16'h0);
    wr(0, DIV2, 16'h0); wr(1, MSK, 16'h0);
  endtask

  task automatic t_down;
    logic [15:0] v, w;
    wr(0, CNT1, 16'd10); wr(0, CTL1, 16'h0007);
    repeat (3) @(negedge clk);
    rd(0, CNT1, v); check("R3 down count", v, 16'd7);
    wr(0, CTL1, 16'h0017);
    rd(0, CNT1, v);
    repeat (5) @(negedge clk);
    rd(0, CNT1, w); check("R3 halt holds", w, v);
  endtask

  task automatic t_div;
    logic [15:0] v;
    wr(0, CNT1, 16'd0); wr(0, DIV1, 16'd3); wr(0, CTL1, 16'h000F);
    repeat (11) @(negedge clk);
    rd(0, CNT1, v); check("R4 divider 3", v, 16'd2);
    wr(0, CTL1, 16'h001F); wr(0, DIV1, 16'd0);
  endtask

  task automatic t_zero;
    logic [15:0] v;
    wr(0, CNT1, 16'd5); wr(0, CTL1, 16'h0000);
    repeat (8) @(negedge clk);
    rd(0, CNT1, v); check("R5 zero count", v, 16'd0);
    rd(0, CTL1, v); check("R5 self halt", v, 16'h0010);
    rd(1, STS, v); check("R5 no status", v, 16'h0);
  endtask

  task automatic t_match;
    logic [15:0] v;
    wr(0, mreg(2), 16'd8); wr(1, MSK, 16'h0004); wr(0, CNT1, 16'd3);
    wr(0, CTL1, 16'h000B);
    repeat (5) @(negedge clk);
    check("R10 irq latency", 16'(irq_o), 16'h0);
    @(negedge clk);
    check("R10 irq raised", 16'(irq_o), 16'h1);
    rd(0, CNT1, v); check("R6 match count", v, 16'd8);
    rd(0, CTL1, v); check("R6 self halt", v, 16'h001B);
    rd(1, STS, v); check("R6 status bit2", v, 16'h0004);
    wr(1, STS, 16'h0004);
    @(negedge clk);
    check("R9 irq after ack", 16'(irq_o), 16'h0);
    rd(1, STS, v); check("R9 ack clears", v, 16'h0);
    wr(1, MSK, 16'h0);
  endtask

  task automatic t_mask;
    logic [15:0] v;
    wr(0, mreg(0), 16'd2); wr(0, CNT1, 16'd0); wr(0, CTL1, 16'h0009);
    repeat (4) @(negedge clk);
    check("R10 masked irq", 16'(irq_o), 16'h0);
    rd(1, STS, v); check("R6 status bit0", v, 16'h0001);
    wr(1, STS, 16'h003F);
  endtask

  task automatic t_collide;
    logic [15:0] v;
    wr(0, CNT1, 16'd0); wr(0, CTL1, 16'h0009);
    @(negedge clk);
    wr(1, STS, 16'h0001);
    rd(1, STS, v); check("R9 hit beats ack", v, 16'h0001);
    wr(1, STS, 16'h0001);
    rd(1, STS, v); check("R9 second ack", v, 16'h0);
  endtask

  task automatic t_wrap;
    logic [15:0] v;
    wr(0, CNT1, 16'hFFFE); wr(0, CTL1, 16'h000F);
    repeat (3) @(negedge clk);
    rd(0, CNT1, v); check("R7 wrap", v, 16'h0001);
    rd(0, CTL1, v); check("R7 still running", v, 16'h000F);
    rd(1, STS, v); check("R7 no status", v, 16'h0);
    wr(0, CTL1, 16'h0010);
  endtask

  task automatic t_sub2;
    logic [15:0] v;
    wr(0, mreg(0), 16'd3); wr(1, MSK, 16'h003F); wr(0, CNT2, 16'd0);
    wr(0, CTL2, 16'h0009);
    repeat (9) @(negedge clk);
    rd(0, CNT2, v); check("R8 sub2 passes match", v, 16'd9);
    rd(0, CTL2, v); check("R8 sub2 running", v, 16'h0009);
    rd(1, STS, v); check("R8 no status", v, 16'h0);
    check("R8 no irq", 16'(irq_o), 16'h0);
    wr(0, CTL2, 16'h0010); wr(1, MSK, 16'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset; t_map; t_down; t_div; t_zero; t_match; t_mask; t_collide; t_wrap; t_sub2;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule